// File: doc/BRIEF.md
# Audio DMA Channel Control and Status Registers

This block is the register front end that a host processor sees for a three-channel audio DMA controller. The channels are capture, playback and microphone capture. Accesses arrive on a plain addressed port that carries a size code for byte, word or dword. The block decodes each access at fixed offsets. It stores the host-owned fields: descriptor list base, last-valid index and control. It shows the fields the channel engines own (current index, prefetch index, remaining sample count, halted and current-equals-last) as read-only values.

Each channel engine reports events as single-cycle set pulses: FIFO error, buffer completion and last-valid completion. The host clears these pending bits by writing a one to them. Each channel keeps its own interrupt line. The line is re-evaluated only when the channel's pending set changes. The block merges the channel lines into one level interrupt and mirrors each line into the global status word.

The block also holds a global control word with warm and cold reset triggers, a global status word, and a one-shot semaphore. Software uses the semaphore to claim access to the codec register path.

Top module: `aud_dma_csr`

## Requirements
- R1: Channel c (c < NCH) occupies addresses 16*c to 16*c+15, selected by address bits 5:4 with bits 7:6 zero. The byte fields are current index at +4, last-valid index at +5, prefetch index at +10 and control at +11. The word fields are status at +6 and sample count at +8. The dword field is the descriptor base at +0, and a write to it forces its two low bits to zero. Index fields are zero-extended on reads.
- R2: A dword read at +4 returns current index in bits 7:0, last-valid in bits 15:8 and status in bits 31:16. A dword read at +8 returns count in bits 15:0, prefetch in bits 23:16 and control in bits 31:24.
- R3: A read with any size/address pair that is not mapped returns 0xFFFFFFFF. A write with such a pair changes no state.
- R4: Status bits 4 (FIFO error), 3 (completion) and 2 (last-valid complete) are set by the engine pulses ev_fifo, ev_done and ev_last. Writing a one to a bit clears it, through a byte write or a word write at +6. Bit 1 shows eng_celv and bit 0 shows eng_halt, and writes do not affect them. When a set pulse and a clear hit the same bit in the same cycle, the set wins. A byte read at +6 returns status bits 7:0.
- R5: A control byte write with bit 1 clear stores bits 4:0. Bit 4 is the completion interrupt enable, bit 3 the FIFO error enable, bit 2 the last-valid enable and bit 0 run. A write with bit 1 set instead resets the channel. The reset clears base, last-valid and all pending bits, keeps control bits 4:2, clears run, and pulses ch_reset for one cycle. A last-valid write keeps the low IDX_W bits.
- R6: A channel line is recomputed only in a cycle where its pending set changes. If the new set is empty, the line drops. If last-valid complete is pending with bit 2 enabled, or completion is pending with bit 4 enabled, the line rises. Otherwise the line holds its value. A FIFO error never raises it.
- R7: irq is the OR of the channel lines and changes on the clock edge that applies the causing write or event. Global status bit 5+c shows the line of channel c.
- R8: A dword write to 0x2C with bit 2 or bit 1 set pulses warm_rst or cold_rst, respectively, for one cycle after the edge, and leaves the stored control value unchanged. Any other dword write to 0x2C stores bits 5:0, which a dword read returns.
- R9: The global status word at 0x30 is 18 bits. Bits 0, 10, 11 and 15 are set by gsta_evt[0], [1], [2] and [3] and are write-one-to-clear. Bits 17:16 are read/write. The remaining bits are read-only. Bit 8 always reads 1, and the other read-only bits read 0 apart from the channel lines.
- R10: A byte read at 0x34 returns the semaphore in bit 0 and sets the semaphore to 1 on the following edge. A codec_touch pulse clears it to 0 and wins over a simultaneous read.
- R11: After reset, all stored fields, pending bits, lines, the semaphore and the global words are zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword |
| acc_addr | input | 8 | Byte address of the access |
| acc_wdata | input | 32 | Write data, right-aligned |
| acc_rdata | output | 32 | Read data for the current address and size |
| codec_touch | input | 1 | Pulse on any codec register access |
| ev_fifo | input | NCH | FIFO error set pulse per channel |
| ev_done | input | NCH | Buffer completion set pulse per channel |
| ev_last | input | NCH | Last-valid completion set pulse per channel |
| eng_celv | input | NCH | Current-equals-last flag per channel |
| eng_halt | input | NCH | Halted flag per channel |
| eng_civ | input | NCH*IDX_W | Current index per channel |
| eng_piv | input | NCH*IDX_W | Prefetch index per channel |
| eng_cnt | input | NCH*CNT_W | Remaining sample count per channel |
| gsta_evt | input | 4 | Set pulses for global status bits 0, 10, 11, 15 |
| ch_base | output | NCH*32 | Descriptor base per channel |
| ch_lvi | output | NCH*IDX_W | Last-valid index per channel |
| ch_ctrl | output | NCH*5 | Control field per channel |
| ch_reset | output | NCH | One-cycle channel reset pulse |
| gctl | output | 6 | Stored global control |
| warm_rst | output | 1 | Warm reset pulse |
| cold_rst | output | 1 | Cold reset pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: three channels, 5-bit indices and 16-bit counts. At these values the third channel sits at 0x20, right below the global control word at 0x2C. The decode therefore has to reject in-channel offsets that belong to global registers. The 5-bit index makes the modulo wrap of a last-valid write visible. Each engine input holds a distinct per-channel value, so any wrong channel select in the combined dword reads or the mirrored global bits shows up as a wrong value.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;
   typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2} acc_sz_e;

   localparam logic [3:0] OFF_BASE = 4'h0;
   localparam logic [3:0] OFF_CUR  = 4'h4;
   localparam logic [3:0] OFF_LAST = 4'h5;
   localparam logic [3:0] OFF_STS  = 4'h6;
   localparam logic [3:0] OFF_CNT  = 4'h8;
   localparam logic [3:0] OFF_PRE  = 4'hA;
   localparam logic [3:0] OFF_CTL  = 4'hB;

   localparam logic [7:0] ADR_GCTL = 8'h2C;
   localparam logic [7:0] ADR_GSTS = 8'h30;
   localparam logic [7:0] ADR_SEM  = 8'h34;

   localparam int GS_W         = 18;
   localparam int GS_LINE_BASE = 5;
   localparam int GS_READY     = 8;
   localparam logic [GS_W-1:0] GS_W1C = 18'h08C01;
   localparam logic [GS_W-1:0] GS_RW  = 18'h30000;

   localparam int CTL_W      = 5;
   localparam int CTL_RUN    = 0;
   localparam int CTL_RST    = 1;
   localparam int CTL_EN_LST = 2;
   localparam int CTL_EN_DON = 4;
   localparam logic [CTL_W-1:0] CTL_KEEP = 5'b11100;
endpackage

// File: rtl/aud_csr_chan.sv
module aud_csr_chan
   import aud_csr_pkg::*;
#(
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_base,
   input  logic             wr_last,
   input  logic             wr_ctl,
   input  logic             wr_sts,
   input  logic [31:0]      wdata,
   input  logic             ev_fifo,
   input  logic             ev_done,
   input  logic             ev_last,
   output logic [31:0]      base_q,
   output logic [IDX_W-1:0] last_q,
   output logic [CTL_W-1:0] ctl_q,
   output logic [2:0]       pend_q,   // {fifo, done, last}
   output logic             line_q,
   output logic             rst_pulse_q
);
   logic             do_rst;
   logic [2:0]       clr, pend_nx;
   logic             line_nx;
   logic [CTL_W-1:0] ctl_nx;

   always_comb begin
      do_rst  = wr_ctl && wdata[CTL_RST];
      clr     = wr_sts ? wdata[4:2] : 3'b000;
      pend_nx = do_rst ? 3'b000 : ((pend_q & ~clr) | {ev_fifo, ev_done, ev_last});
      line_nx = line_q;
      if (pend_nx != pend_q) begin
         if (pend_nx == 3'b000)
            line_nx = 1'b0;
         else if ((pend_nx[0] && ctl_q[CTL_EN_LST]) || (pend_nx[1] && ctl_q[CTL_EN_DON]))
            line_nx = 1'b1;
      end
      if (do_rst)      ctl_nx = ctl_q & CTL_KEEP;
      else if (wr_ctl) ctl_nx = wdata[CTL_W-1:0];
      else             ctl_nx = ctl_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q      <= '0;
         last_q      <= '0;
         ctl_q       <= '0;
         pend_q      <= '0;
         line_q      <= 1'b0;
         rst_pulse_q <= 1'b0;
      end else begin
         pend_q      <= pend_nx;
         line_q      <= line_nx;
         ctl_q       <= ctl_nx;
         rst_pulse_q <= do_rst;
         if (do_rst)       base_q <= '0;
         else if (wr_base) base_q <= {wdata[31:2], 2'b00};
         if (do_rst)       last_q <= '0;
         else if (wr_last) last_q <= wdata[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/aud_csr_glob.sv
module aud_csr_glob
   import aud_csr_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_gctl,
   input  logic            wr_gsts,
   input  logic            rd_sem,
   input  logic            codec_touch,
   input  logic [GS_W-1:0] wdata,
   input  logic [3:0]      gsta_evt,
   output logic [5:0]      gctl_q,
   output logic [GS_W-1:0] gsts_q,
   output logic            sem_q,
   output logic            warm_q,
   output logic            cold_q
);
   logic [GS_W-1:0] set_v, gsts_nx;
   logic            store_ctl;

   always_comb begin
      set_v     = '0;
      set_v[0]  = gsta_evt[0];
      set_v[10] = gsta_evt[1];
      set_v[11] = gsta_evt[2];
      set_v[15] = gsta_evt[3];
      gsts_nx   = gsts_q;
      if (wr_gsts)
         gsts_nx = ((gsts_q & ~(wdata & GS_W1C)) & ~GS_RW) | (wdata & GS_RW);
      gsts_nx   = (gsts_nx | set_v) & (GS_W1C | GS_RW);
      store_ctl = wr_gctl && !wdata[2] && !wdata[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gctl_q <= '0;
         gsts_q <= '0;
         sem_q  <= 1'b0;
         warm_q <= 1'b0;
         cold_q <= 1'b0;
      end else begin
         gsts_q <= gsts_nx;
         warm_q <= wr_gctl && wdata[2];
         cold_q <= wr_gctl && wdata[1];
         if (store_ctl)    gctl_q <= wdata[5:0];
         if (codec_touch)  sem_q  <= 1'b0;
         else if (rd_sem)  sem_q  <= 1'b1;
      end
   end
endmodule

// File: rtl/aud_dma_csr.sv
module aud_dma_csr
   import aud_csr_pkg::*;
#(
   parameter int NCH   = 3,
   parameter int IDX_W = 5,
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic                 acc_write,
   input  logic [1:0]           acc_size,
   input  logic [7:0]           acc_addr,
   input  logic [31:0]          acc_wdata,
   output logic [31:0]          acc_rdata,
   input  logic                 codec_touch,
   input  logic [NCH-1:0]       ev_fifo,
   input  logic [NCH-1:0]       ev_done,
   input  logic [NCH-1:0]       ev_last,
   input  logic [NCH-1:0]       eng_celv,
   input  logic [NCH-1:0]       eng_halt,
   input  logic [NCH*IDX_W-1:0] eng_civ,
   input  logic [NCH*IDX_W-1:0] eng_piv,
   input  logic [NCH*CNT_W-1:0] eng_cnt,
   input  logic [3:0]           gsta_evt,
   output logic [NCH*32-1:0]    ch_base,
   output logic [NCH*IDX_W-1:0] ch_lvi,
   output logic [NCH*5-1:0]     ch_ctrl,
   output logic [NCH-1:0]       ch_reset,
   output logic [5:0]           gctl,
   output logic                 warm_rst,
   output logic                 cold_rst,
   output logic                 irq
);
   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("NCH must be 1 to 3");
   end
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must be 1 to 8");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must be 1 to 16");
   end

   logic       wr_en, in_ch, is_b, is_w, is_d;
   logic [1:0] ch_sel;
   logic [3:0] off;

   assign wr_en  = acc_valid && acc_write;
   assign ch_sel = acc_addr[5:4];
   assign off    = acc_addr[3:0];
   assign in_ch  = (acc_addr[7:6] == 2'b00) && (32'(ch_sel) < NCH);
   assign is_b   = acc_size == SZ_BYTE;
   assign is_w   = acc_size == SZ_WORD;
   assign is_d   = acc_size == SZ_DWORD;

   logic [31:0]      base_a [NCH];
   logic [IDX_W-1:0] last_a [NCH];
   logic [CTL_W-1:0] ctl_a  [NCH];
   logic [15:0]      sts_a  [NCH];
   logic [NCH-1:0]   line_v;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic       hit;
      logic [2:0] pend;
      assign hit = in_ch && (ch_sel == 2'(c));

      aud_csr_chan #(.IDX_W(IDX_W)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_base     (wr_en && hit && is_d && off == OFF_BASE),
         .wr_last     (wr_en && hit && is_b && off == OFF_LAST),
         .wr_ctl      (wr_en && hit && is_b && off == OFF_CTL),
         .wr_sts      (wr_en && hit && (is_b || is_w) && off == OFF_STS),
         .wdata       (acc_wdata),
         .ev_fifo     (ev_fifo[c]),
         .ev_done     (ev_done[c]),
         .ev_last     (ev_last[c]),
         .base_q      (base_a[c]),
         .last_q      (last_a[c]),
         .ctl_q       (ctl_a[c]),
         .pend_q      (pend),
         .line_q      (line_v[c]),
         .rst_pulse_q (ch_reset[c])
      );

      assign sts_a[c] = {11'b0, pend, eng_celv[c], eng_halt[c]};
      assign ch_base[c*32 +: 32]       = base_a[c];
      assign ch_lvi[c*IDX_W +: IDX_W]  = last_a[c];
      assign ch_ctrl[c*CTL_W +: CTL_W] = ctl_a[c];
   end

   logic [GS_W-1:0] gsts_q, gs_view;
   logic            sem_q;

   aud_csr_glob u_glob (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_gctl     (wr_en && is_d && acc_addr == ADR_GCTL),
      .wr_gsts     (wr_en && is_d && acc_addr == ADR_GSTS),
      .rd_sem      (acc_valid && !acc_write && is_b && acc_addr == ADR_SEM),
      .codec_touch (codec_touch),
      .wdata       (acc_wdata[GS_W-1:0]),
      .gsta_evt    (gsta_evt),
      .gctl_q      (gctl),
      .gsts_q      (gsts_q),
      .sem_q       (sem_q),
      .warm_q      (warm_rst),
      .cold_q      (cold_rst)
   );

   always_comb begin
      gs_view           = gsts_q;
      gs_view[GS_READY] = 1'b1;
      for (int c = 0; c < NCH; c++) gs_view[GS_LINE_BASE + c] = line_v[c];
   end

   assign irq = |line_v;

   always_comb begin
      acc_rdata = '1;
      for (int c = 0; c < NCH; c++) begin
         if (in_ch && ch_sel == 2'(c)) begin
            if (is_b) begin
               case (off)
                  OFF_CUR:  acc_rdata = 32'(eng_civ[c*IDX_W +: IDX_W]);
                  OFF_LAST: acc_rdata = 32'(last_a[c]);
                  OFF_STS:  acc_rdata = {24'b0, sts_a[c][7:0]};
                  OFF_PRE:  acc_rdata = 32'(eng_piv[c*IDX_W +: IDX_W]);
                  OFF_CTL:  acc_rdata = 32'(ctl_a[c]);
                  default:  ;
               endcase
            end else if (is_w) begin
               case (off)
                  OFF_STS: acc_rdata = {16'b0, sts_a[c]};
                  OFF_CNT: acc_rdata = 32'(eng_cnt[c*CNT_W +: CNT_W]);
                  default: ;
               endcase
            end else if (is_d) begin
               case (off)
                  OFF_BASE: acc_rdata = base_a[c];
                  OFF_CUR:  acc_rdata = {sts_a[c], 8'(last_a[c]), 8'(eng_civ[c*IDX_W +: IDX_W])};
                  OFF_CNT:  acc_rdata = {8'(ctl_a[c]), 8'(eng_piv[c*IDX_W +: IDX_W]),
                                         16'(eng_cnt[c*CNT_W +: CNT_W])};
                  default:  ;
               endcase
            end
         end
      end
      if (is_d && acc_addr == ADR_GCTL) acc_rdata = 32'(gctl);
      if (is_d && acc_addr == ADR_GSTS) acc_rdata = 32'(gs_view);
      if (is_b && acc_addr == ADR_SEM)  acc_rdata = 32'(sem_q);
   end
endmodule

// File: rtl/aud_dma_csr_chk.sv
module aud_dma_csr_chk #(
   parameter int NCH   = 3,
   parameter int IDX_W = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_valid,
   input logic                 acc_write,
   input logic [1:0]           acc_size,
   input logic [7:0]           acc_addr,
   input logic [31:0]          acc_wdata,
   input logic [31:0]          acc_rdata,
   input logic                 codec_touch,
   input logic [NCH*32-1:0]    ch_base,
   input logic [NCH*IDX_W-1:0] ch_lvi,
   input logic [NCH*5-1:0]     ch_ctrl,
   input logic [5:0]           gctl,
   input logic                 warm_rst
);
   logic rd_b, rd_d, wr_b, wr_d;
   assign rd_b = acc_valid && !acc_write && acc_size == 2'd0;
   assign rd_d = acc_valid && !acc_write && acc_size == 2'd2;
   assign wr_b = acc_valid && acc_write && acc_size == 2'd0;
   assign wr_d = acc_valid && acc_write && acc_size == 2'd2;

   // R9
   gsts_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_d && acc_addr == 8'h30) |-> acc_rdata[8]);

   // R10
   sem_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b && acc_addr == 8'h34 && !codec_touch) |=>
      (!(rd_b && acc_addr == 8'h34) || acc_rdata == 32'h1));

   // R3
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b && acc_addr == 8'h3F) |-> acc_rdata == 32'hFFFF_FFFF);

   // R8
   warm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && acc_addr == 8'h2C && acc_wdata[2]) |=> warm_rst);

   // R8
   gctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_d && acc_addr == 8'h2C && (acc_wdata[2] || acc_wdata[1])) |=> $stable(gctl));

   // R5
   chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_b && acc_addr == 8'h0B && acc_wdata[1]) |=>
      (ch_base[31:0] == 32'h0 && ch_lvi[IDX_W-1:0] == '0 && !ch_ctrl[0]));
endmodule

bind aud_dma_csr aud_dma_csr_chk #(.NCH(NCH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/aud_dma_csr_tb.sv
`timescale 1ns/100ps
module aud_dma_csr_tb_top;
   localparam int NCH = 3, IDX_W = 5, CNT_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0;
   logic [1:0] acc_size = 0;
   logic [7:0] acc_addr = 0;
   logic [31:0] acc_wdata = 0, acc_rdata;
   logic codec_touch = 0;
   logic [NCH-1:0] ev_fifo = 0, ev_done = 0, ev_last = 0;
   logic [NCH-1:0] eng_celv = 3'b010, eng_halt = 3'b101;
   logic [NCH*IDX_W-1:0] eng_civ = {5'd5, 5'd4, 5'd3};
   logic [NCH*IDX_W-1:0] eng_piv = {5'd6, 5'd5, 5'd4};
   logic [NCH*CNT_W-1:0] eng_cnt = {16'h1232, 16'h1231, 16'h1230};
   logic [3:0] gsta_evt = 0;
   logic [NCH*32-1:0] ch_base;
   logic [NCH*IDX_W-1:0] ch_lvi;
   logic [NCH*5-1:0] ch_ctrl;
   logic [NCH-1:0] ch_reset;
   logic [5:0] gctl;
   logic warm_rst, cold_rst, irq;

   int vectors = 0, miscomp = 0;

   always #2.5 clk = ~clk;

   aud_dma_csr #(.NCH(NCH), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut_i (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1; acc_write = 1; acc_size = sz; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 0; acc_write = 0;
   endtask

   task automatic bus_rd(input logic [1:0] sz, input logic [7:0] a, output logic [31:0] q);
      @(negedge clk);
      acc_valid = 1; acc_write = 0; acc_size = sz; acc_addr = a;
      #1 q = acc_rdata;
      @(negedge clk);
      acc_valid = 0;
   endtask

   task automatic chk_rd(input string req, input logic [1:0] sz, input logic [7:0] a,
                         input logic [31:0] exp);
      logic [31:0] q;
      bus_rd(sz, a, q);
      check(req, q, exp);
   endtask

   task automatic pulse(input logic [2:0] f, input logic [2:0] dn, input logic [2:0] l,
                        input logic [3:0] g, input logic ct);
      @(negedge clk);
      ev_fifo = f; ev_done = dn; ev_last = l; gsta_evt = g; codec_touch = ct;
      @(negedge clk);
      ev_fifo = 0; ev_done = 0; ev_last = 0; gsta_evt = 0; codec_touch = 0;
   endtask

   task automatic t_reset();
      check("R11 irq", {31'b0, irq}, 0);
      chk_rd("R11 base", 2'd2, 8'h00, 32'h0);
      chk_rd("R11 status", 2'd1, 8'h06, 32'h1);
      chk_rd("R11 ctrl", 2'd0, 8'h0B, 32'h0);
      chk_rd("R11 gctl", 2'd2, 8'h2C, 32'h0);
      chk_rd("R11 gsts", 2'd2, 8'h30, 32'h100);
      chk_rd("R11 sem", 2'd0, 8'h34, 32'h0);
   endtask

   task automatic t_sem();
      chk_rd("R10 sem set", 2'd0, 8'h34, 32'h1);
      pulse(0, 0, 0, 0, 1);
      chk_rd("R10 sem cleared", 2'd0, 8'h34, 32'h0);
      pulse(0, 0, 0, 0, 1);
      bus_wr(2'd2, 8'h34, 32'h1);
      chk_rd("R3 sem write ignored", 2'd0, 8'h34, 32'h0);
   endtask

   task automatic t_map();
      bus_wr(2'd2, 8'h10, 32'h1234_5677);
      chk_rd("R1 base", 2'd2, 8'h10, 32'h1234_5674);
      check("R1 base port", ch_base[63:32], 32'h1234_5674);
      bus_wr(2'd0, 8'h25, 32'h27);
      chk_rd("R1 lvi wrap", 2'd0, 8'h25, 32'h7);
      chk_rd("R2 dword +4", 2'd2, 8'h24, 32'h0001_0705);
      chk_rd("R2 dword +8", 2'd2, 8'h18, 32'h0005_1231);
      chk_rd("R1 civ", 2'd0, 8'h14, 32'h4);
      chk_rd("R1 piv", 2'd0, 8'h1A, 32'h5);
      chk_rd("R1 count", 2'd1, 8'h28, 32'h1232);
      chk_rd("R3 byte 0x3F", 2'd0, 8'h3F, 32'hFFFF_FFFF);
      chk_rd("R3 word +4", 2'd1, 8'h04, 32'hFFFF_FFFF);
      chk_rd("R3 dword +6", 2'd2, 8'h06, 32'hFFFF_FFFF);
      chk_rd("R3 byte gctl", 2'd0, 8'h2C, 32'hFFFF_FFFF);
      bus_wr(2'd0, 8'h10, 32'hFF);
      chk_rd("R3 byte base write", 2'd2, 8'h10, 32'h1234_5674);
   endtask

   task automatic t_irq_ch0();
      bus_wr(2'd0, 8'h0B, 32'h04);
      pulse(0, 0, 3'b001, 0, 0);
      check("R6 last raises", {31'b0, irq}, 1);
      chk_rd("R7 gsts line0", 2'd2, 8'h30, 32'h120);
      chk_rd("R4 status last", 2'd1, 8'h06, 32'h5);
      pulse(0, 3'b001, 0, 0, 0);
      chk_rd("R4 status done", 2'd0, 8'h06, 32'hD);
      bus_wr(2'd0, 8'h06, 32'h04);
      check("R6 hold nonempty", {31'b0, irq}, 1);
      chk_rd("R4 clear last", 2'd1, 8'h06, 32'h9);
      bus_wr(2'd1, 8'h06, 32'h08);
      check("R6 empty drops", {31'b0, irq}, 0);
      chk_rd("R7 gsts idle", 2'd2, 8'h30, 32'h100);
   endtask

   task automatic t_fifo_ch1();
      bus_wr(2'd0, 8'h1B, 32'h08);
      pulse(3'b010, 0, 0, 0, 0);
      check("R6 fifo no irq", {31'b0, irq}, 0);
      chk_rd("R4 status fifo", 2'd1, 8'h16, 32'h12);
      bus_wr(2'd1, 8'h16, 32'h13);
      chk_rd("R4 clear ro kept", 2'd1, 8'h16, 32'h02);
      @(negedge clk);
      ev_last = 3'b010; acc_valid = 1; acc_write = 1; acc_size = 2'd0;
      acc_addr = 8'h16; acc_wdata = 32'h04;
      @(negedge clk);
      ev_last = 0; acc_valid = 0; acc_write = 0;
      chk_rd("R4 set wins", 2'd1, 8'h16, 32'h06);
      bus_wr(2'd0, 8'h16, 32'h04);
   endtask

   task automatic t_chreset();
      bus_wr(2'd0, 8'h1B, 32'h15);
      check("R5 ctrl port", 32'(ch_ctrl[9:5]), 32'h15);
      bus_wr(2'd2, 8'h10, 32'hABCD_0001);
      bus_wr(2'd0, 8'h15, 32'h09);
      pulse(0, 3'b010, 0, 0, 0);
      check("R6 done raises", {31'b0, irq}, 1);
      chk_rd("R7 gsts line1", 2'd2, 8'h30, 32'h140);
      bus_wr(2'd0, 8'h1B, 32'h03);
      check("R5 reset pulse", 32'(ch_reset), 32'h2);
      check("R6 reset drops irq", {31'b0, irq}, 0);
      chk_rd("R5 base zero", 2'd2, 8'h10, 32'h0);
      chk_rd("R5 lvi zero", 2'd0, 8'h15, 32'h0);
      chk_rd("R5 ctrl kept", 2'd0, 8'h1B, 32'h14);
      chk_rd("R5 status clr", 2'd1, 8'h16, 32'h02);
   endtask

   task automatic t_gctl();
      bus_wr(2'd2, 8'h2C, 32'h3F);
      check("R8 warm", {31'b0, warm_rst}, 1);
      check("R8 cold", {31'b0, cold_rst}, 1);
      chk_rd("R8 not stored", 2'd2, 8'h2C, 32'h0);
      bus_wr(2'd2, 8'h2C, 32'h39);
      check("R8 no pulse", {30'b0, warm_rst, cold_rst}, 0);
      chk_rd("R8 stored", 2'd2, 8'h2C, 32'h39);
      bus_wr(2'd2, 8'h2C, 32'hFFFF_FFC1);
      chk_rd("R8 low bits", 2'd2, 8'h2C, 32'h01);
      bus_wr(2'd2, 8'h2C, 32'h02);
      check("R8 cold only", {30'b0, warm_rst, cold_rst}, 1);
      chk_rd("R8 kept", 2'd2, 8'h2C, 32'h01);
   endtask

   task automatic t_gsts();
      pulse(0, 0, 0, 4'hF, 0);
      chk_rd("R9 events", 2'd2, 8'h30, 32'h8D01);
      bus_wr(2'd2, 8'h30, 32'h0003_0801);
      chk_rd("R9 w1c rw", 2'd2, 8'h30, 32'h3_8500);
      bus_wr(2'd2, 8'h30, 32'h0000_72FE);
      chk_rd("R9 ro ignored", 2'd2, 8'h30, 32'h8500);
      bus_wr(2'd2, 8'h30, 32'h0000_8400);
      chk_rd("R9 cleared", 2'd2, 8'h30, 32'h100);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sem();
      t_map();
      t_irq_ch0();
      t_fifo_ch1();
      t_chreset();
      t_gctl();
      t_gsts();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      vectors++;
      miscomp++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end
endmodule